// File: doc/BRIEF.md
# Broadcast-Hit Readout Channel Selector

Every digitiser module in a detector array hears a shared stream of hit messages. A message names a pixel and carries a 2-bit level code that says which of three discriminator levels the pixel crossed. This block sits in one module and works out which of its own local channels must be read out for the hits it hears. The pair of pixel number and level code addresses a table. Each table entry is a mask of local channels, usually the hit pixel and the six pixels around it, where they belong to this module.

The first valid hit after an idle period opens a coincidence window. The window length is programmable in clock cycles, and 4000 cycles (40 µs at 100 MHz) is the usual setting. Every valid hit inside the window ORs its table mask into an accumulator. When the window expires, the block raises one request strobe together with the accumulated channel mask and then clears the accumulator. A hit that lands in the closing cycle of a window opens the next window, so events that follow each other closely are both recorded. The table can only be rewritten while no window is open.

Top module: `hit_readout_selector`

## Requirements
- R1: After reset the request strobe and the request mask are low, no window is open, and every table entry holds an all-zero mask.
- R2: A table write while no window is open stores `tbl_data` at address {pixel, code}, with the pixel in the upper bits and the code in the low 2 bits. A later hit with that pixel and code uses the stored mask.
- R3: A hit with code 0 is ignored. It opens no window and adds nothing to the mask of an open window.
- R4: A hit with a nonzero code presented in cycle n while no window is open starts a window. With window length W, hits presented in cycles n+1 to n+W-1 join that window, and its request strobe is high in cycle n+W+1.
- R5: The request mask is the bitwise OR of the table masks of all valid hits that belonged to the window.
- R6: The request strobe lasts one cycle. `rd_mask` carries the mask only in that cycle and is zero otherwise. The next window starts from an empty mask.
- R7: A window whose accumulated mask is all zero expires without raising the request strobe.
- R8: A valid hit presented in the closing cycle of a window (cycle n+W) is not lost. It opens a new window that starts in that cycle.
- R9: A table write presented while a window is open is discarded, and this includes the closing cycle of the window.
- R10: The window length is taken from `win_len` when the window opens. Later changes to `win_len` do not affect that window, and a length of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | Hit message strobe |
| hit_pix | input | PIX_W | Broadcast pixel number |
| hit_code | input | CODE_W | Discriminator level code, 0 = no crossing |
| win_len | input | WIN_W | Coincidence window length in cycles |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | PIX_W+CODE_W | Table write address {pixel, code} |
| tbl_data | input | CH_N | Channel mask to store |
| rd_req | output | 1 | Readout request strobe |
| rd_mask | output | CH_N | Local channels to read out |

## Verification
The bench builds the block with a 5-bit pixel number, 12 local channels and an 8-bit window length. With these values a window of the largest length (255 cycles) runs in a short simulation, and the zero-length case and the wrap of the down-counter can be reached directly. The small table also lets the bench fill chosen entries and read them back through hits. The scoreboard predicts the exact cycle and mask of every request. This covers hits at the last cycle that still joins a window, hits in the closing cycle, one-cycle windows with hits on every cycle, and table writes attempted in the middle and at the close of a window.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
   typedef enum logic {
      WIN_IDLE = 1'b0,
      WIN_OPEN = 1'b1
   } win_state_e;

   function automatic int unsigned addr_width(input int unsigned pix_w,
                                              input int unsigned code_w);
      return pix_w + code_w;
   endfunction
endpackage

// File: rtl/hrs_table.sv
module hrs_table #(
   parameter int unsigned PIX_W       = 7,
   parameter int unsigned CODE_W      = 2,
   parameter int unsigned CH_N        = 16,
   parameter bit          TABLE_CLEAR = 1'b1,
   localparam int unsigned AW         = hrs_pkg::addr_width(PIX_W, CODE_W),
   localparam int unsigned DEPTH      = 1 << AW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [CH_N-1:0] wr_data,
   input  logic [AW-1:0]   rd_addr,
   output logic [CH_N-1:0] rd_data
);
   logic [CH_N-1:0] ent [DEPTH];

   if (PIX_W < 1)  begin : g_bad_pix  $error("hrs_table: PIX_W must be at least 1");  end
   if (CODE_W < 1) begin : g_bad_code $error("hrs_table: CODE_W must be at least 1"); end
   if (CH_N < 1)   begin : g_bad_ch   $error("hrs_table: CH_N must be at least 1");   end
   if (AW > 12)    begin : g_bad_aw   $error("hrs_table: table address too wide");    end

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
      logic hit_here;
      assign hit_here = wr_en && (wr_addr == AW'(gi));
      if (TABLE_CLEAR) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n)        ent[gi] <= '0;
            else if (hit_here) ent[gi] <= wr_data;
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (hit_here) ent[gi] <= wr_data;
         end
      end
   end

   assign rd_data = ent[rd_addr];
endmodule

// File: rtl/hrs_window.sv
module hrs_window #(
   parameter int unsigned WIN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_ok,
   input  logic [WIN_W-1:0] win_len,
   output logic             open,
   output logic             closing
);
   import hrs_pkg::*;

   win_state_e       st_q;
   logic [WIN_W-1:0] cnt_q;
   logic [WIN_W-1:0] load_val;

   if (WIN_W < 1) begin : g_bad_w $error("hrs_window: WIN_W must be at least 1"); end

   assign load_val = (win_len == '0) ? '0 : win_len - WIN_W'(1);
   assign open     = (st_q == WIN_OPEN);
   assign closing  = open && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= WIN_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            WIN_IDLE: begin
               if (hit_ok) begin
                  st_q  <= WIN_OPEN;
                  cnt_q <= load_val;
               end
            end
            WIN_OPEN: begin
               if (cnt_q == '0) begin
                  if (hit_ok) cnt_q <= load_val;
                  else        st_q  <= WIN_IDLE;
               end else begin
                  cnt_q <= cnt_q - WIN_W'(1);
               end
            end
            default: st_q <= WIN_IDLE;
         endcase
      end
   end

   AST_OPEN_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!open && hit_ok) |=> open); // R4
   AST_NO_EARLY_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      (open && !closing) |=> open); // R4
   AST_CLOSE_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (closing && hit_ok) |=> open); // R8
endmodule

// File: rtl/hrs_accum.sv
module hrs_accum #(
   parameter int unsigned CH_N = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            add_en,
   input  logic [CH_N-1:0] add_mask,
   input  logic            closing,
   output logic            rd_req,
   output logic [CH_N-1:0] rd_mask
);
   logic [CH_N-1:0] acc_q;
   logic [CH_N-1:0] acc_base;
   logic [CH_N-1:0] acc_d;
   logic            fire;

   assign acc_base = closing ? '0 : acc_q;
   assign acc_d    = acc_base | (add_en ? add_mask : '0);
   assign fire     = closing && (acc_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= '0;
         rd_req  <= 1'b0;
         rd_mask <= '0;
      end else begin
         acc_q   <= acc_d;
         rd_req  <= fire;
         rd_mask <= fire ? acc_q : '0;
      end
   end

   AST_REQ_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (rd_mask != '0)); // R7
   AST_REQ_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> $past(closing)); // R4
   AST_ACC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      !closing |=> ((acc_q & $past(acc_q)) == $past(acc_q))); // R5
   AST_MASK_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |-> (rd_mask == '0)); // R6
endmodule

// File: rtl/hit_readout_selector.sv
module hit_readout_selector #(
   parameter int unsigned PIX_W       = 7,
   parameter int unsigned CODE_W      = 2,
   parameter int unsigned CH_N        = 16,
   parameter int unsigned WIN_W       = 16,
   parameter bit          TABLE_CLEAR = 1'b1,
   localparam int unsigned AW         = PIX_W + CODE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_valid,
   input  logic [PIX_W-1:0] hit_pix,
   input  logic [CODE_W-1:0] hit_code,
   input  logic [WIN_W-1:0] win_len,
   input  logic             tbl_we,
   input  logic [AW-1:0]    tbl_addr,
   input  logic [CH_N-1:0]  tbl_data,
   output logic             rd_req,
   output logic [CH_N-1:0]  rd_mask
);
   logic            hit_ok;
   logic            win_open;
   logic            win_closing;
   logic            wr_grant;
   logic [CH_N-1:0] hit_mask;
   logic [AW-1:0]   rd_addr;

   assign hit_ok   = hit_valid && (hit_code != '0);
   assign wr_grant = tbl_we && !win_open;
   assign rd_addr  = {hit_pix, hit_code};

   hrs_table #(
      .PIX_W      (PIX_W),
      .CODE_W     (CODE_W),
      .CH_N       (CH_N),
      .TABLE_CLEAR(TABLE_CLEAR)
   ) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_grant),
      .wr_addr(tbl_addr),
      .wr_data(tbl_data),
      .rd_addr(rd_addr),
      .rd_data(hit_mask)
   );

   hrs_window #(
      .WIN_W(WIN_W)
   ) u_window (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_ok (hit_ok),
      .win_len(win_len),
      .open   (win_open),
      .closing(win_closing)
   );

   hrs_accum #(
      .CH_N(CH_N)
   ) u_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .add_en  (hit_ok),
      .add_mask(hit_mask),
      .closing (win_closing),
      .rd_req  (rd_req),
      .rd_mask (rd_mask)
   );

   AST_CODE0_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_open && hit_valid && (hit_code == '0)) |=> !win_open); // R3
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_open && !$past(win_open)) |-> !rd_req); // R4
endmodule

// File: tb/sim_hit_readout_selector.sv
module sim_hit_readout_selector;
   localparam int CLK_PERIOD = 10;
   localparam int PIX_W  = 5;
   localparam int CODE_W = 2;
   localparam int CH_N   = 12;
   localparam int WIN_W  = 8;
   localparam int AW     = PIX_W + CODE_W;

   typedef struct {
      int              cyc;
      logic [CH_N-1:0] mask;
      string           tag;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             hit_valid = 1'b0;
   logic [PIX_W-1:0] hit_pix = '0;
   logic [CODE_W-1:0] hit_code = '0;
   logic [WIN_W-1:0] win_len = '0;
   logic             tbl_we = 1'b0;
   logic [AW-1:0]    tbl_addr = '0;
   logic [CH_N-1:0]  tbl_data = '0;
   logic             rd_req;
   logic [CH_N-1:0]  rd_mask;

   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   reported = 0;
   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   hit_readout_selector #(
      .PIX_W(PIX_W), .CODE_W(CODE_W), .CH_N(CH_N), .WIN_W(WIN_W)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_pix(hit_pix),
      .hit_code(hit_code), .win_len(win_len), .tbl_we(tbl_we),
      .tbl_addr(tbl_addr), .tbl_data(tbl_data), .rd_req(rd_req), .rd_mask(rd_mask)
   );

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      end
      $finish;
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         while (q.size() > 0 && q[0].cyc < cyc) begin
            check(1'b0, {q[0].tag, " missing request"}, 0, int'(q[0].mask));
            void'(q.pop_front());
         end
         if (rd_req) begin
            if (q.size() > 0 && q[0].cyc == cyc) begin
               check(rd_mask == q[0].mask, q[0].tag, int'(rd_mask), int'(q[0].mask));
               void'(q.pop_front());
            end else begin
               check(1'b0, "R7 unexpected request", int'(rd_mask), 0);
            end
         end
      end
   end

   task automatic nxt();
      @(negedge clk);
      hit_valid = 1'b0;
      hit_code  = '0;
      tbl_we    = 1'b0;
   endtask

   task automatic go(input int t);
      while (cyc < t) nxt();
   endtask

   task automatic hit(input int p, input int c);
      hit_valid = 1'b1;
      hit_pix   = PIX_W'(p);
      hit_code  = CODE_W'(c);
   endtask

   task automatic wr(input int p, input int c, input int m);
      tbl_we   = 1'b1;
      tbl_addr = {PIX_W'(p), CODE_W'(c)};
      tbl_data = CH_N'(m);
   endtask

   task automatic expect_req(input int at, input int m, input string tag);
      exp_t e;
      e.cyc = at; e.mask = CH_N'(m); e.tag = tag;
      q.push_back(e);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired, pending=%0d expected=0", q.size());
      report();
   end

   initial begin
      int c;
      repeat (4) nxt();
      rst_n = 1'b1;
      nxt();
      check(rd_req == 1'b0, "R1 strobe after reset", int'(rd_req), 0);
      check(rd_mask == '0, "R1 mask after reset", int'(rd_mask), 0);

      // R1: unwritten entry is zero, so no request
      win_len = 8'd4;
      hit(5, 3);
      nxt(); go(cyc + 10);

      // R2: fill the table in idle
      wr(3, 1, 'h00F); nxt();
      wr(3, 2, 'h0F0); nxt();
      wr(7, 3, 'h800); nxt();
      wr(7, 1, 'h000); nxt();
      wr(3, 0, 'hFFF); nxt();
      win_len = 8'd20;

      // R4: single hit
      c = cyc; hit(3, 1);
      expect_req(c + 21, 'h00F, "R4 single hit timing");
      go(c + 30);

      // R5: OR of three hits, the last one at the final joining cycle
      c = cyc; hit(3, 1);
      expect_req(c + 21, 'h8FF, "R5 OR of hits");
      go(c + 5);  hit(3, 2);
      go(c + 19); hit(7, 3);
      go(c + 30);

      // R3: code 0 in idle opens nothing; code 0 inside a window adds nothing
      hit(3, 0); nxt(); go(cyc + 25);
      c = cyc; hit(7, 3);
      expect_req(c + 21, 'h800, "R3 code 0 ignored in window");
      go(c + 3); hit(3, 0);
      go(c + 30);

      // R7: window with zero mask issues no request
      hit(7, 1); nxt(); go(cyc + 25);

      // R8 / R6: hit in closing cycle opens next window, mask starts empty
      c = cyc; hit(3, 1);
      expect_req(c + 21, 'h00F, "R8 first of back-to-back");
      go(c + 20); hit(3, 2);
      expect_req(c + 41, 'h0F0, "R6 second window starts clean");
      go(c + 50);

      // R9: writes during the window and at its close are dropped
      c = cyc; hit(3, 1);
      expect_req(c + 21, 'h00F, "R9 window with blocked writes");
      go(c + 2);  wr(3, 2, 'hABC);
      go(c + 20); wr(9, 1, 'h555);
      go(c + 25);
      c = cyc; hit(3, 2);
      expect_req(c + 21, 'h0F0, "R9 entries unchanged");
      go(c + 1); hit(9, 1);
      go(c + 30);

      // R2: write accepted in idle, used by the next hit
      wr(9, 1, 'h555); nxt();
      c = cyc; hit(9, 1);
      expect_req(c + 21, 'h555, "R2 idle write takes effect");
      go(c + 30);

      // R10: zero length acts as one
      win_len = 8'd0;
      c = cyc; hit(3, 1);
      expect_req(c + 2, 'h00F, "R10 zero length");
      go(c + 6);

      // R10: length latched at open
      win_len = 8'd5;
      c = cyc; hit(3, 2);
      expect_req(c + 6, 'h0F0, "R10 length latched");
      go(c + 1); win_len = 8'd50;
      go(c + 60);

      // R10: longest window
      win_len = 8'd255;
      c = cyc; hit(7, 3);
      expect_req(c + 256, 'h800, "R10 longest window");
      go(c + 260);

      // R8: one-cycle windows with hits on consecutive cycles
      win_len = 8'd1;
      c = cyc; hit(3, 1);
      expect_req(c + 2, 'h00F, "R8 consecutive window A");
      go(c + 1); hit(3, 2);
      expect_req(c + 3, 'h0F0, "R8 consecutive window B");
      go(c + 10);

      check(q.size() == 0, "R4 all expected requests seen", q.size(), 0);
      report();
   end
endmodule